// File: doc/BRIEF.md
# FP8 Fused Multiply-Add into Half Precision

This unit multiplies two 8-bit floating-point operands and adds the product to a 16-bit half-precision accumulator. The accumulator is both a source and the destination. Each 8-bit operand has its own format select, so one can be read as E5M2 and the other as E4M3. The two bytes are widened and multiplied exactly. A 4-bit scale field divides the product by a power of two from 1 to 32768. The scaled product is then added to the accumulator, and only the final sum is rounded.

The unit is a two-stage pipeline, and a valid bit travels with the data. Stage one decodes the operands, forms the exact product and the aligned accumulator on a common fixed-point grid, and adds them in sign-magnitude form. Stage two finds the leading one, rounds in the selected mode, and encodes the half-precision result and the four exception flags. Special operands skip the arithmetic and use a separate path.

Top module: `fp8_fma_h`

## Requirements
- R1: With its format select at 0, an operand is read as E5M2: sign, 5-bit exponent with bias 15, 2 fraction bits. Exponent 0 encodes subnormals. Exponent 31 encodes infinity when the fraction is 0 and NaN otherwise.
- R2: With its format select at 1, an operand is read as E4M3: sign, 4-bit exponent with bias 7, 3 fraction bits. Exponent 0 encodes subnormals. Exponent 15 is a normal binade. Only the magnitude pattern 1111.111 is NaN, and no encoding is infinite.
- R3: The result is the exact value acc + a*b*2^-scale, with scale unsigned in 0..15, rounded once to half precision. No intermediate value is rounded.
- R4: With rmode 00 the unit rounds to nearest, and a tie goes to the even significand.
- R5: rmode 01 rounds toward +infinity, rmode 10 toward -infinity, and rmode 11 toward zero.
- R6: When the rounded magnitude would exceed 65504, flag_overflow and flag_inexact are set. The result is infinity under rmode 00, under rmode 01 for a positive result and under rmode 10 for a negative result. In every other case the result is the largest finite value 0x7BFF, with the result's sign.
- R7: flag_inexact is set whenever the rounded result differs from the exact value. flag_underflow is set when the exact nonzero value is below 2^-14 in magnitude and the result is inexact. An exact subnormal result raises no flag.
- R8: Any NaN operand gives the default NaN 0x7E00, with flag_invalid clear and all other flags clear.
- R9: When no operand is NaN, infinity times zero, or an infinite product added to an infinite accumulator of opposite sign, gives 0x7E00 with flag_invalid set.
- R10: A valid infinite product, or an infinite accumulator, gives an infinite result with the sign of that infinity and no flags.
- R11: An exact zero sum of opposite-signed terms is +0, or -0 under rmode 10. A sum of two zeros of the same sign keeps that sign.
- R12: The result and flags of an operation presented with in_valid appear exactly two clock cycles later, with out_valid high for one cycle per accepted operation.
- R13: While rst_n is low, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs |
| op_a | input | 8 | First 8-bit operand |
| op_b | input | 8 | Second 8-bit operand |
| fmt_a | input | 1 | Format of op_a: 0 E5M2, 1 E4M3 |
| fmt_b | input | 1 | Format of op_b: 0 E5M2, 1 E4M3 |
| scale | input | 4 | Product is multiplied by 2^-scale |
| rmode | input | 2 | 00 nearest-even, 01 up, 10 down, 11 toward zero |
| acc | input | 16 | Half-precision accumulator input |
| out_valid | output | 1 | Result present |
| result | output | 16 | Half-precision result |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Result overflowed |
| flag_underflow | output | 1 | Tiny and inexact result |
| flag_inexact | output | 1 | Result was rounded |

## Verification
The directed cases place a large accumulator next to a small product, so the sum lands exactly on a tie or just above one. A unit that rounds in two steps, or that drops sticky bits, returns 2048 where 2050 is expected. It also fails to round the tie 2051 up to 2052. Boundary stimulus checks the E4M3 top binade, which a decoder that treats it as infinite turns into infinity. It also checks the 2^-32 product, which a unit without sticky tracking returns as zero or with the underflow flag missing. Overflow runs under every rounding mode, so a unit that always saturates to infinity is caught. The zero-sum and infinity cases catch a wrong sign on zero and a missing invalid flag. Constrained-random traffic is compared against an exact wide-integer reference model.

// File: rtl/fp8_fma_h.sv
module fp8_fma_h #(
  parameter int W = 84
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  op_a,
  input  logic [7:0]  op_b,
  input  logic        fmt_a,
  input  logic        fmt_b,
  input  logic [3:0]  scale,
  input  logic [1:0]  rmode,
  input  logic [15:0] acc,
  output logic        out_valid,
  output logic [15:0] result,
  output logic        flag_invalid,
  output logic        flag_overflow,
  output logic        flag_underflow,
  output logic        flag_inexact
);
  localparam int PW = $clog2(W);

  // {nan, inf, lsb exponent + 24, significand}
  function automatic logic [11:0] dec8(input logic [7:0] b, input logic f);
    logic nan, inf;
    logic [5:0] x;
    logic [3:0] m;
    if (f) begin
      nan = (b[6:0] == 7'h7F);
      inf = 1'b0;
      m   = {|b[6:3], b[2:0]};
      x   = (b[6:3] == 4'd0) ? 6'd15 : {2'b00, b[6:3]} + 6'd14;
    end else begin
      nan = (&b[6:2]) & (|b[1:0]);
      inf = (&b[6:2]) & ~(|b[1:0]);
      m   = {1'b0, |b[6:2], b[1:0]};
      x   = (b[6:2] == 5'd0) ? 6'd8 : {1'b0, b[6:2]} + 6'd7;
    end
    return {nan, inf, x, m};
  endfunction

  wire [11:0] da = dec8(op_a, fmt_a);
  wire [11:0] db = dec8(op_b, fmt_b);
  wire a_zero = ~da[10] & (da[3:0] == 4'd0);
  wire b_zero = ~db[10] & (db[3:0] == 4'd0);
  wire [7:0] pm  = {4'b0, da[3:0]} * {4'b0, db[3:0]};
  wire [6:0] psh = {1'b0, da[9:4]} + {1'b0, db[9:4]} - 7'd1 - {3'b0, scale};
  wire [W-1:0] pmag = W'(pm) << psh;

  wire [4:0]  ae   = acc[14:10];
  wire [10:0] am   = {|ae, acc[9:0]};
  wire [6:0]  ash  = (ae == 5'd0) ? 7'd23 : {2'b00, ae} + 7'd22;
  wire [W-1:0] amag = W'(am) << ash;
  wire acc_nan = (&ae) & (|acc[9:0]);
  wire acc_inf = (&ae) & ~(|acc[9:0]);

  wire ps     = op_a[7] ^ op_b[7];
  wire p_inf  = (da[10] & ~b_zero) | (db[10] & ~a_zero);
  wire nan_in = da[11] | db[11] | acc_nan;
  wire inv    = ~nan_in & ((da[10] & b_zero) | (db[10] & a_zero) |
                           (p_inf & acc_inf & (ps != acc[15])));
  wire spec   = nan_in | inv | p_inf | acc_inf;
  wire [15:0] sres = (nan_in | inv) ? 16'h7E00 : p_inf ? {ps, 15'h7C00} : acc;

  wire same = (ps == acc[15]);
  wire ge   = (pmag >= amag);
  wire [W-1:0] smag = same ? pmag + amag : ge ? pmag - amag : amag - pmag;
  wire ssign = (smag == '0 && !same) ? (rmode == 2'b10) : (same | ge) ? ps : acc[15];

  logic         v1, r_spec, r_inv, r_sign;
  logic [15:0]  r_sres;
  logic [1:0]   r_rm;
  logic [W-1:0] r_mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; r_spec <= 1'b0; r_inv <= 1'b0; r_sign <= 1'b0;
      r_sres <= '0; r_rm <= '0; r_mag <= '0;
    end else begin
      v1 <= in_valid; r_spec <= spec; r_inv <= inv; r_sign <= ssign;
      r_sres <= sres; r_rm <= rmode; r_mag <= smag;
    end
  end

  logic [PW-1:0] lead;
  always_comb begin
    lead = '0;
    for (int i = 0; i < W; i++)
      if (r_mag[i]) lead = PW'(i);
  end

  wire          norm  = (lead >= PW'(33));
  wire [PW-1:0] sh    = norm ? lead - PW'(10) : PW'(23);
  wire [W-1:0]  shq   = r_mag >> sh;
  wire [W-1:0]  shg   = r_mag >> (sh - PW'(1));
  wire          guard = shg[0];
  wire          stick = |(r_mag & ((W'(1) << (sh - PW'(1))) - W'(1)));
  wire          inex  = guard | stick;
  logic up;
  always_comb begin
    case (r_rm)
      2'b00:   up = guard & (stick | shq[0]);
      2'b01:   up = inex & ~r_sign;
      2'b10:   up = inex & r_sign;
      default: up = 1'b0;
    endcase
  end
  wire [16:0] base = norm ? (17'(lead - PW'(33)) << 10) : 17'd0;
  wire [16:0] tot  = base + {6'b0, shq[10:0]} + {16'b0, up};
  wire        ovf  = (tot >= 17'h07C00);
  wire        away = (r_rm == 2'b00) | (r_rm == 2'b01 & ~r_sign) | (r_rm == 2'b10 & r_sign);
  wire [14:0] fin  = ovf ? (away ? 15'h7C00 : 15'h7BFF) : tot[14:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; result <= '0;
      flag_invalid <= 1'b0; flag_overflow <= 1'b0;
      flag_underflow <= 1'b0; flag_inexact <= 1'b0;
    end else begin
      out_valid      <= v1;
      result         <= r_spec ? r_sres : {r_sign, fin};
      flag_invalid   <= r_spec & r_inv;
      flag_overflow  <= ~r_spec & ovf;
      flag_underflow <= ~r_spec & ~norm & inex;
      flag_inexact   <= ~r_spec & (inex | ovf);
    end
  end
endmodule

// File: rtl/fp8_fma_h_chk.sv
module fp8_fma_h_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] acc,
  input logic        out_valid,
  input logic [15:0] result,
  input logic        flag_invalid,
  input logic        flag_overflow,
  input logic        flag_underflow,
  input logic        flag_inexact
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R13
  AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R12
  AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid); // R12
  AST_NAN_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc[14:10] == 5'h1F && acc[9:0] != 10'd0) |=> ##1
    (result == 16'h7E00 && !flag_invalid)); // R8
  AST_INVALID_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_invalid) |->
    (result == 16'h7E00 && !flag_overflow && !flag_underflow && !flag_inexact)); // R9
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_overflow) |->
    (flag_inexact && (result[14:0] == 15'h7C00 || result[14:0] == 15'h7BFF))); // R6
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_underflow) |-> (flag_inexact && result[14:10] <= 5'd1)); // R7
endmodule

bind fp8_fma_h fp8_fma_h_chk u_chk (.*);

// File: tb/test_fp8_fma_h.sv
module test_fp8_fma_h;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic fmt_a = 1'b0, fmt_b = 1'b0;
  logic [3:0] scale = '0;
  logic [1:0] rmode = '0;
  logic [15:0] acc = '0;
  logic out_valid, flag_invalid, flag_overflow, flag_underflow, flag_inexact;
  logic [15:0] result;

  int errors = 0, checks = 0, cyc = 0;
  logic [19:0] exp_q[$];
  string tag_q[$];
  int cyc_q[$];

  fp8_fma_h i_fp8_fma_h (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void dec(input logic [7:0] v, input logic f,
                              output bit n, output bit i, output int m, output int x);
    int ef, fr;
    if (f) begin
      ef = int'(v[6:3]); fr = int'(v[2:0]);
      n = (ef == 15 && fr == 7); i = 1'b0;
      m = (ef == 0 ? 0 : 8) + fr; x = (ef == 0 ? 1 : ef) - 10;
    end else begin
      ef = int'(v[6:2]); fr = int'(v[1:0]);
      n = (ef == 31 && fr != 0); i = (ef == 31 && fr == 0);
      m = (ef == 0 ? 0 : 4) + fr; x = (ef == 0 ? 1 : ef) - 17;
    end
  endfunction

  // returns {invalid, overflow, underflow, inexact, result}
  function automatic logic [19:0] ref_fma(input logic [7:0] a, input logic [7:0] b,
      input logic fa, input logic fb, input logic [3:0] sc, input logic [1:0] rm,
      input logic [15:0] c);
    bit an, ai, bn, bi, cn, ci, ps, neg, up, inx, unf, az, bz;
    int am, ax, bm, bx, cm, cx, ce, p, sh, q, e;
    logic signed [127:0] pv, av, sv;
    logic [127:0] mag, unit, rem, half;
    dec(a, fa, an, ai, am, ax);
    dec(b, fb, bn, bi, bm, bx);
    ce = int'(c[14:10]);
    cn = (ce == 31 && c[9:0] != 10'd0);
    ci = (ce == 31 && c[9:0] == 10'd0);
    cm = (ce == 0 ? 0 : 1024) + int'(c[9:0]);
    cx = (ce == 0 ? 1 : ce) - 25;
    ps = a[7] ^ b[7];
    az = !ai && am == 0;
    bz = !bi && bm == 0;
    if (an || bn || cn) return {4'b0000, 16'h7E00};
    if ((ai && bz) || (bi && az)) return {4'b1000, 16'h7E00};
    if (ai || bi) begin
      if (ci && c[15] != ps) return {4'b1000, 16'h7E00};
      return {4'b0000, ps, 15'h7C00};
    end
    if (ci) return {4'b0000, c};
    pv = 128'(am * bm) <<< (ax + bx - int'(sc) + 47);
    if (ps) pv = -pv;
    av = 128'(cm) <<< (cx + 47);
    if (c[15]) av = -av;
    sv = pv + av;
    neg = sv[127];
    mag = neg ? 128'(-sv) : 128'(sv);
    if (mag == 0) return {4'b0000, (ps == c[15]) ? ps : (rm == 2'b10), 15'h0000};
    p = 0;
    for (int i = 127; i >= 0; i--) if (mag[i]) begin p = i; break; end
    sh = (p >= 33) ? p - 10 : 23;
    unit = 128'd1 << sh;
    q = int'(mag / unit);
    rem = mag % unit;
    half = unit >> 1;
    inx = (rem != 0);
    case (rm)
      2'b00: up = (rem > half) || (rem == half && q[0]);
      2'b01: up = inx && !neg;
      2'b10: up = inx && neg;
      default: up = 1'b0;
    endcase
    q = q + (up ? 1 : 0);
    e = (p >= 33) ? p - 32 : 0;
    if (q == 2048) begin q = 1024; e = e + 1; end
    else if (e == 0 && q == 1024) e = 1;
    unf = (p < 33) && inx;
    if (e >= 31) begin
      if (rm == 2'b00 || (rm == 2'b01 && !neg) || (rm == 2'b10 && neg))
        return {4'b0101, neg, 15'h7C00};
      return {4'b0101, neg, 15'h7BFF};
    end
    return {2'b00, unf, inx, neg, 5'(e), 10'(q)};
  endfunction

  task automatic issue(input logic [7:0] a, input logic [7:0] b, input logic fa,
      input logic fb, input logic [3:0] sc, input logic [1:0] rm, input logic [15:0] c,
      input logic [19:0] expv, input string tag);
    @(negedge clk);
    op_a = a; op_b = b; fmt_a = fa; fmt_b = fb; scale = sc; rmode = rm; acc = c;
    in_valid = 1'b1;
    exp_q.push_back(expv); tag_q.push_back(tag); cyc_q.push_back(cyc);
  endtask

  task automatic dir(input logic [7:0] a, input logic [7:0] b, input logic fa,
      input logic fb, input logic [3:0] sc, input logic [1:0] rm, input logic [15:0] c,
      input logic [19:0] expv, input string tag);
    issue(a, b, fa, fb, sc, rm, c, expv, tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12: out_valid with no pending operation, actual result %h expected none", result);
      end else begin
        logic [19:0] got, want;
        string t;
        int c0;
        want = exp_q.pop_front(); t = tag_q.pop_front(); c0 = cyc_q.pop_front();
        got = {flag_invalid, flag_overflow, flag_underflow, flag_inexact, result};
        if (got !== want) begin
          errors++;
          $display("FAIL %s: actual flags/result %h expected %h", t, got, want);
        end
        checks++;
        if (cyc != c0 + 2) begin
          errors++;
          $display("FAIL R12: latency actual %0d expected 2", cyc - c0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd51873));
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R13: out_valid in reset actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    dir(8'h38, 8'h3C, 1'b1, 1'b0, 4'd0, 2'b00, 16'h0000, 20'h0_3C00, "R2 R1 mixed 1x1");
    dir(8'h3C, 8'h38, 1'b0, 1'b1, 4'd0, 2'b00, 16'h0000, 20'h0_3C00, "R1 R2 swapped formats");
    dir(8'h01, 8'h3C, 1'b0, 1'b0, 4'd0, 2'b00, 16'h0000, 20'h0_0100, "R1 E5M2 subnormal exact");
    dir(8'h7D, 8'h3C, 1'b0, 1'b0, 4'd0, 2'b00, 16'h3C00, 20'h0_7E00, "R1 R8 E5M2 NaN");
    dir(8'h78, 8'h38, 1'b1, 1'b1, 4'd0, 2'b00, 16'h0000, 20'h0_5C00, "R2 E4M3 exp15 finite");
    dir(8'h7E, 8'h38, 1'b1, 1'b1, 4'd0, 2'b00, 16'h0000, 20'h0_5F00, "R2 E4M3 max 448");
    dir(8'h7F, 8'h38, 1'b1, 1'b1, 4'd0, 2'b00, 16'h0000, 20'h0_7E00, "R2 R8 E4M3 NaN");
    dir(8'h01, 8'h38, 1'b1, 1'b1, 4'd0, 2'b00, 16'h0000, 20'h0_1800, "R2 E4M3 subnormal");
    dir(8'h40, 8'h40, 1'b0, 1'b0, 4'd2, 2'b00, 16'h3C00, 20'h0_4000, "R3 scale 2");
    dir(8'h40, 8'h40, 1'b0, 1'b0, 4'd15, 2'b00, 16'h0000, 20'h0_0800, "R3 scale 15");
    dir(8'h39, 8'h38, 1'b1, 1'b1, 4'd0, 2'b00, 16'h6800, 20'h1_6801, "R3 R4 sticky above tie");
    dir(8'h38, 8'h38, 1'b1, 1'b1, 4'd0, 2'b00, 16'h6800, 20'h1_6800, "R4 tie to even down");
    dir(8'h44, 8'h38, 1'b1, 1'b1, 4'd0, 2'b00, 16'h6800, 20'h1_6802, "R4 tie to even up");
    dir(8'h39, 8'h38, 1'b1, 1'b1, 4'd0, 2'b01, 16'h6800, 20'h1_6801, "R5 round up");
    dir(8'h39, 8'h38, 1'b1, 1'b1, 4'd0, 2'b10, 16'h6800, 20'h1_6800, "R5 round down");
    dir(8'h39, 8'h38, 1'b1, 1'b1, 4'd0, 2'b11, 16'h6800, 20'h1_6800, "R5 toward zero");
    dir(8'hB9, 8'h38, 1'b1, 1'b1, 4'd0, 2'b10, 16'hE800, 20'h1_E801, "R5 round down negative");
    dir(8'hB9, 8'h38, 1'b1, 1'b1, 4'd0, 2'b01, 16'hE800, 20'h1_E800, "R5 round up negative");
    dir(8'h7B, 8'h3C, 1'b0, 1'b0, 4'd0, 2'b00, 16'h7BFF, 20'h5_7C00, "R6 overflow nearest");
    dir(8'h7B, 8'h3C, 1'b0, 1'b0, 4'd0, 2'b11, 16'h7BFF, 20'h5_7BFF, "R6 overflow toward zero");
    dir(8'h7B, 8'h3C, 1'b0, 1'b0, 4'd0, 2'b10, 16'h7BFF, 20'h5_7BFF, "R6 overflow down positive");
    dir(8'hFB, 8'h3C, 1'b0, 1'b0, 4'd0, 2'b10, 16'hFBFF, 20'h5_FC00, "R6 overflow down negative");
    dir(8'h01, 8'h01, 1'b0, 1'b0, 4'd0, 2'b00, 16'h0000, 20'h3_0000, "R7 underflow to zero");
    dir(8'h01, 8'h01, 1'b0, 1'b0, 4'd0, 2'b01, 16'h0000, 20'h3_0001, "R7 underflow round up");
    dir(8'h3C, 8'h3C, 1'b0, 1'b0, 4'd0, 2'b00, 16'h7E01, 20'h0_7E00, "R8 NaN accumulator");
    dir(8'h7C, 8'h00, 1'b0, 1'b0, 4'd0, 2'b00, 16'h3C00, 20'h8_7E00, "R9 inf times zero");
    dir(8'h7C, 8'h3C, 1'b0, 1'b0, 4'd0, 2'b00, 16'hFC00, 20'h8_7E00, "R9 inf minus inf");
    dir(8'h7C, 8'hBC, 1'b0, 1'b0, 4'd0, 2'b00, 16'h3C00, 20'h0_FC00, "R10 negative inf product");
    dir(8'h3C, 8'h3C, 1'b0, 1'b0, 4'd0, 2'b00, 16'h7C00, 20'h0_7C00, "R10 inf accumulator");
    dir(8'h3C, 8'h3C, 1'b0, 1'b0, 4'd0, 2'b00, 16'hBC00, 20'h0_0000, "R11 cancel to +0");
    dir(8'h3C, 8'h3C, 1'b0, 1'b0, 4'd0, 2'b10, 16'hBC00, 20'h0_8000, "R11 cancel to -0 rounding down");
    dir(8'h80, 8'h3C, 1'b0, 1'b0, 4'd0, 2'b00, 16'h8000, 20'h0_8000, "R11 negative zeros");

    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a, b;
      logic fa, fb;
      logic [3:0] sc;
      logic [1:0] rm;
      logic [15:0] c;
      a = 8'($urandom); b = 8'($urandom);
      fa = 1'($urandom); fb = 1'($urandom);
      sc = 4'($urandom); rm = 2'($urandom);
      c = 16'($urandom);
      if (k % 3 == 0) c[14:10] = 5'(($urandom % 12) + 6);
      issue(a, b, fa, fb, sc, rm, c, ref_fma(a, b, fa, fb, sc, rm, c), "R3 random");
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12: pending results actual %0d expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule